// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses, for each of the two ALU source operands in the execute stage of a five-stage load/store pipeline, where the operand value should come from. Without it, an instruction that reads a register written by one of the two instructions just ahead of it would see a stale register-file value. The block compares each source register number of the instruction in execute with the destination register numbers of the two older instructions still in flight. A comparison only counts when that older instruction will actually write a register, and never when the register is the hard-wired zero register.

For each operand the block produces a 2-bit select code and drives the chosen value onto the operand output through a three-way multiplexer. The three choices are the register-file read value, the ALU result one stage ahead, and the write-back value two stages ahead. When both older instructions target the same source register, the younger of the two wins. The block is purely combinational. It sits between the execute-stage pipeline register and the ALU inputs.

Top module: `operand_bypass_unit`

## Requirements
- R1: When no qualifying producer matches a source register, its select code is 00 and the operand output equals the register-file read value for that operand.
- R2: When the one-ahead stage has its write enable set, a nonzero destination, and a destination equal to the source register, the select code is 10 and the operand equals the one-ahead ALU result.
- R3: When only the two-ahead stage qualifies (write enable set, nonzero destination equal to the source), the select code is 01 and the operand equals the two-ahead write-back value.
- R4: A source register number of 0 is never forwarded: the select code is 00 and the register-file value passes through, whatever the producers hold.
- R5: A producer whose write enable is low is ignored even if its destination equals the source register.
- R6: When both producers qualify for the same source register, the one-ahead stage wins (select 10).
- R7: Operands A and B are decided independently, so in one evaluation A and B may take different sources, including both being forwarded.
- R8: The select code 11 is never produced on either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the instruction in execute |
| src_b_idx | input | 5 | Second source register number of the instruction in execute |
| rf_a_val | input | 32 | Register-file value read for the first source |
| rf_b_val | input | 32 | Register-file value read for the second source |
| near_wr_en | input | 1 | One-ahead instruction writes a register |
| near_dst_idx | input | 5 | Destination register number of the one-ahead instruction |
| near_alu_val | input | 32 | ALU result of the one-ahead instruction |
| far_wr_en | input | 1 | Two-ahead instruction writes a register |
| far_dst_idx | input | 5 | Destination register number of the two-ahead instruction |
| far_wb_val | input | 32 | Write-back value of the two-ahead instruction |
| sel_a | output | 2 | Source select for operand A (00 regfile, 01 two-ahead, 10 one-ahead) |
| sel_b | output | 2 | Source select for operand B (same encoding) |
| opnd_a | output | 32 | Selected operand A for the ALU |
| opnd_b | output | 32 | Selected operand B for the ALU |

## Verification
Every result of this block is due in the same cycle as its stimulus, since no register lies between any input and any output. The bench therefore drives a full input vector, waits a fixed settling delay well short of the next clock edge, and only then samples both select codes and both operands. Expected values come from the priority rule restated as plain arithmetic on the register numbers, so each vector is judged without any clocked latency to account for.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  // Source-select encoding; bit positions are decoded by the operand muxes.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_FAR     = 2'b01,
    SRC_NEAR    = 2'b10
  } src_sel_e;

  // Priority resolution: the younger producer wins over the older one.
  function automatic src_sel_e pick_source(input logic near_hit, input logic far_hit);
    if (near_hit)     return SRC_NEAR;
    else if (far_hit) return SRC_FAR;
    else              return SRC_REGFILE;
  endfunction

endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
  parameter int IDX_W = 5
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             hit
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic dst_live;
  logic idx_equal;

  assign dst_live  = wr_en && (dst_idx != ZERO_IDX);
  assign idx_equal = (dst_idx == src_idx);
  assign hit       = dst_live && idx_equal;

endmodule

// File: rtl/bypass_select.sv
module bypass_select
  import bypass_pkg::*;
(
  input  logic       near_hit,
  input  logic       far_hit,
  output logic [1:0] sel
);

  src_sel_e choice;

  always_comb begin
    choice = pick_source(near_hit, far_hit);
  end

  assign sel = choice;

endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] far_val,
  input  logic [DATA_W-1:0] near_val,
  output logic [DATA_W-1:0] out_val
);

  always_comb begin
    unique case (sel)
      SRC_NEAR: out_val = near_val;
      SRC_FAR:  out_val = far_val;
      default:  out_val = rf_val;
    endcase
  end

endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [DATA_W-1:0] rf_a_val,
  input  logic [DATA_W-1:0] rf_b_val,
  input  logic              near_wr_en,
  input  logic [IDX_W-1:0]  near_dst_idx,
  input  logic [DATA_W-1:0] near_alu_val,
  input  logic              far_wr_en,
  input  logic [IDX_W-1:0]  far_dst_idx,
  input  logic [DATA_W-1:0] far_wb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int NUM_OPND = 2;

  logic [NUM_OPND-1:0][IDX_W-1:0]  src_idx;
  logic [NUM_OPND-1:0][DATA_W-1:0] rf_val;
  logic [NUM_OPND-1:0][DATA_W-1:0] opnd_val;
  logic [NUM_OPND-1:0][1:0]        opnd_sel;

  // Named internal events, one bit per operand.
  logic [NUM_OPND-1:0] near_hit;
  logic [NUM_OPND-1:0] far_hit;

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;
  assign rf_val[0]  = rf_a_val;
  assign rf_val[1]  = rf_b_val;

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    bypass_match #(.IDX_W(IDX_W)) u_near_match (
      .wr_en   (near_wr_en),
      .dst_idx (near_dst_idx),
      .src_idx (src_idx[k]),
      .hit     (near_hit[k])
    );

    bypass_match #(.IDX_W(IDX_W)) u_far_match (
      .wr_en   (far_wr_en),
      .dst_idx (far_dst_idx),
      .src_idx (src_idx[k]),
      .hit     (far_hit[k])
    );

    bypass_select u_sel (
      .near_hit (near_hit[k]),
      .far_hit  (far_hit[k]),
      .sel      (opnd_sel[k])
    );

    bypass_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (opnd_sel[k]),
      .rf_val   (rf_val[k]),
      .far_val  (far_wb_val),
      .near_val (near_alu_val),
      .out_val  (opnd_val[k])
    );
  end

  assign sel_a  = opnd_sel[0];
  assign sel_b  = opnd_sel[1];
  assign opnd_a = opnd_val[0];
  assign opnd_b = opnd_val[1];

endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  src_a_idx,
  input logic [IDX_W-1:0]  src_b_idx,
  input logic [DATA_W-1:0] rf_a_val,
  input logic [DATA_W-1:0] rf_b_val,
  input logic              near_wr_en,
  input logic [IDX_W-1:0]  near_dst_idx,
  input logic [DATA_W-1:0] near_alu_val,
  input logic              far_wr_en,
  input logic [IDX_W-1:0]  far_dst_idx,
  input logic [DATA_W-1:0] far_wb_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);

  always_comb begin
    AST_SEL_A_LEGAL: assert (sel_a != 2'b11);  // R8
    AST_SEL_B_LEGAL: assert (sel_b != 2'b11);  // R8
    AST_ZERO_SRC_A: assert (src_a_idx != '0 || sel_a == 2'b00);  // R4
    AST_ZERO_SRC_B: assert (src_b_idx != '0 || sel_b == 2'b00);  // R4
    AST_IDLE_PRODUCERS: assert (near_wr_en || far_wr_en || (sel_a == 2'b00 && sel_b == 2'b00));  // R5
    AST_RF_PASS_A: assert (sel_a != 2'b00 || opnd_a == rf_a_val);  // R1
    AST_NEAR_PASS_A: assert (sel_a != 2'b10 || opnd_a == near_alu_val);  // R2
    AST_FAR_PASS_B: assert (sel_b != 2'b01 || opnd_b == far_wb_val);  // R3
    AST_NEAR_WINS_A: assert (!(near_wr_en && far_wr_en && near_dst_idx == far_dst_idx
                               && near_dst_idx == src_a_idx && src_a_idx != '0) || sel_a == 2'b10);  // R6
  end

endmodule

bind operand_bypass_unit operand_bypass_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
  .src_a_idx    (src_a_idx),
  .src_b_idx    (src_b_idx),
  .rf_a_val     (rf_a_val),
  .rf_b_val     (rf_b_val),
  .near_wr_en   (near_wr_en),
  .near_dst_idx (near_dst_idx),
  .near_alu_val (near_alu_val),
  .far_wr_en    (far_wr_en),
  .far_dst_idx  (far_dst_idx),
  .far_wb_val   (far_wb_val),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b)
);

// File: tb/operand_bypass_unit_tb_top.sv
`timescale 1ns/1ps
module operand_bypass_unit_tb_top;

  localparam int IW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [IW-1:0] src_a_idx, src_b_idx, near_dst_idx, far_dst_idx;
  logic [DW-1:0] rf_a_val, rf_b_val, near_alu_val, far_wb_val;
  logic          near_wr_en, far_wr_en;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  operand_bypass_unit #(.IDX_W(IW), .DATA_W(DW)) dut_i (
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .rf_a_val(rf_a_val), .rf_b_val(rf_b_val),
    .near_wr_en(near_wr_en), .near_dst_idx(near_dst_idx), .near_alu_val(near_alu_val),
    .far_wr_en(far_wr_en), .far_dst_idx(far_dst_idx), .far_wb_val(far_wb_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected select from the requirement, stated arithmetically.
  function automatic int exp_sel(input int src, input int nwe, input int nd, input int fwe, input int fd);
    int near_q, far_q;
    near_q = (src != 0) * nwe * (nd == src);
    far_q  = (src != 0) * fwe * (fd == src);
    return near_q * 2 + (1 - near_q) * far_q;
  endfunction

  function automatic string tag_of(input int src, input int nwe, input int nd, input int fwe, input int fd);
    int nq, fq;
    nq = nwe * (nd == src);
    fq = fwe * (fd == src);
    if (src == 0) return "R4";
    if (nq == 1 && fq == 1) return "R6";
    if (nq == 1) return "R2";
    if (fq == 1) return "R3";
    if (nd == src || fd == src) return "R5";
    return "R1";
  endfunction

  function automatic logic [DW-1:0] exp_val(input int s, input logic [DW-1:0] rf);
    if (s == 2) return near_alu_val;
    if (s == 1) return far_wb_val;
    return rf;
  endfunction

  task automatic apply(input int a, input int b, input int nwe, input int nd, input int fwe, input int fd, input int seq);
    src_a_idx    = IW'(a);
    src_b_idx    = IW'(b);
    near_wr_en   = nwe[0];
    near_dst_idx = IW'(nd);
    far_wr_en    = fwe[0];
    far_dst_idx  = IW'(fd);
    rf_a_val     = 32'hA000_0000 + DW'(seq);
    rf_b_val     = 32'hB000_0000 + DW'(seq);
    near_alu_val = 32'hC000_0000 + DW'(seq);
    far_wb_val   = 32'hD000_0000 + DW'(seq);
    #1;
  endtask

  task automatic check_vec(input int a, input int b, input int nwe, input int nd, input int fwe, input int fd);
    int sa, sb;
    sa = exp_sel(a, nwe, nd, fwe, fd);
    sb = exp_sel(b, nwe, nd, fwe, fd);
    chk(tag_of(a, nwe, nd, fwe, fd), "sel_a", DW'(sel_a), DW'(sa));
    chk(tag_of(a, nwe, nd, fwe, fd), "opnd_a", opnd_a, exp_val(sa, rf_a_val));
    chk(tag_of(b, nwe, nd, fwe, fd), "sel_b", DW'(sel_b), DW'(sb));
    chk(tag_of(b, nwe, nd, fwe, fd), "opnd_b", opnd_b, exp_val(sb, rf_b_val));
    chk("R8", "sel_a/sel_b not 11", DW'((sel_a == 2'b11) || (sel_b == 2'b11)), '0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seq;
    seq = 0;
    apply(0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #5;
    // Reset-state / idle: everything passes through (R1)
    chk("R1", "idle sel_a", DW'(sel_a), 0);
    chk("R1", "idle opnd_b", opnd_b, rf_b_val);

    // Near-exhaustive sweep over register numbers 0..7
    for (int nwe = 0; nwe < 2; nwe++)
      for (int fwe = 0; fwe < 2; fwe++)
        for (int nd = 0; nd < 8; nd++)
          for (int fd = 0; fd < 8; fd++)
            for (int a = 0; a < 8; a++)
              for (int b = 0; b < 8; b++) begin
                seq++;
                apply(a, b, nwe, nd, fwe, fd, seq);
                check_vec(a, b, nwe, nd, fwe, fd);
                #1;
              end

    // Top register number boundary
    apply(31, 31, 1, 31, 1, 31, 1001);
    chk("R6", "r31 both match sel_a", DW'(sel_a), 2);
    chk("R6", "r31 both match opnd_b", opnd_b, near_alu_val);
    apply(31, 30, 0, 31, 1, 31, 1002);
    chk("R5", "near disabled sel_a", DW'(sel_a), 1);
    chk("R1", "r30 unmatched opnd_b", opnd_b, rf_b_val);

    // R7: both operands forwarded from different producers at once
    apply(12, 17, 1, 17, 1, 12, 1003);
    chk("R7", "A from far", opnd_a, far_wb_val);
    chk("R7", "B from near", opnd_b, near_alu_val);
    chk("R7", "sel pair", DW'({sel_a, sel_b}), DW'(4'b0110));

    // R4: zero source with producers writing register zero
    apply(0, 0, 1, 0, 1, 0, 1004);
    chk("R4", "zero src opnd_a", opnd_a, rf_a_val);
    chk("R4", "zero src sel_b", DW'(sel_b), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule